// File: doc/BRIEF.md
# Secure-Banked Interrupt CPU Interface

This block is the per-processor end of an interrupt controller. It sits between a distributor and one CPU. The distributor presents its best pending interrupt: an identifier, an 8-bit priority (a lower value is more urgent), a flag that marks the interrupt as non-secure, and a 3-bit source CPU number for software interrupts. The block decides whether that interrupt may interrupt the CPU, and drives the IRQ and FIQ lines accordingly. It hands acknowledge and completion pulses back to the distributor.

The CPU reaches the block through a small memory-mapped window. Every access carries a security attribute, and several registers show a different view depending on that attribute. Two control bits decide how cross-security interrupts are handled. One lets a secure reader take and complete non-secure interrupts. The other makes the secure binary point govern both worlds. A short stack of active priorities gives the running priority. Read data returns one cycle after the access with a valid strobe. Register state changes on the same clock edge as the access.

Top module: `sec_cpu_intf`

## Requirements
- R1: After reset, these values hold: control reads 0, the priority mask reads 0, both binary points read 0, and running priority reads 0xF0. IRQ and FIQ are low. An acknowledge read returns 1023.
- R2: Register offsets are fixed: control 0x100, priority mask 0x104, binary point 0x108, acknowledge 0x10C, completion 0x110, running priority 0x114, highest pending 0x118, non-secure binary point alias 0x11C, identification 0x120. The control bits are: bit 0 secure enable, bit 1 non-secure enable, bit 2 cross-acknowledge, bit 3 secure-to-FIQ routing, bit 4 shared binary point. The priority mask is held in bits 7:3 and the other mask bits read 0.
- R3: The identification register reads 0x3901043B, and writes to it have no effect.
- R4: An interrupt is signalled only when the pending priority is strictly below both the mask and the running priority, and the matching enable is set. A secure interrupt goes to FIQ when routing is on, and to IRQ otherwise. A non-secure interrupt always goes to IRQ. IRQ and FIQ are never high together.
- R5: An acknowledge read that takes an interrupt returns the source in bits 12:10 and the identifier in bits 9:0. It pushes the interrupt onto the active stack. For one cycle it pulses the acknowledge strobe, with the identifier and source on the feedback outputs.
- R6: A secure acknowledge read while a non-secure interrupt is pending has two outcomes. With cross-acknowledge 0, it returns 1022 and changes nothing. With cross-acknowledge 1, it takes the interrupt.
- R7: A non-secure acknowledge read while a secure interrupt is pending returns 1023. A read that returns 1022 or 1023 produces no acknowledge pulse and leaves the running priority unchanged.
- R8: A completion write whose bits 9:0 and 12:10 match the top of the active stack pops it and pulses the completion strobe. A write that does not match is ignored.
- R9: There are three cases for completing an interrupt across security states. A secure completion of a non-secure active interrupt is ignored when cross-acknowledge is 0, and pops it when cross-acknowledge is 1. A non-secure completion of a secure active interrupt is always ignored.
- R10: Running priority reads as the top active priority with bits 3:0 cleared, or 0xF0 when the stack is empty. When the stack is full, an acknowledge read returns 1023 and takes nothing.
- R11: With the shared binary point bit set, three things change. Non-secure writes to 0x108 are ignored. Non-secure reads of 0x108 return the secure binary point plus 1, saturating at 7. Secure accesses keep using the secure binary point.
- R12: Banked views work as follows. A non-secure access to control sees and writes only bit 1. A non-secure read of 0x11C returns 0, and a non-secure write to it is ignored. A secure access to 0x11C reads and writes the non-secure binary point, which non-secure accesses to 0x108 use when the shared bit is 0.
- R13: The highest-pending read returns the same identifier view as acknowledge, with one difference: it is not gated by priority. It has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendValid | input | 1 | Distributor has a pending interrupt |
| pendId | input | 10 | Pending interrupt identifier |
| pendPrio | input | 8 | Pending interrupt priority, lower is more urgent |
| pendNs | input | 1 | Pending interrupt is non-secure |
| pendSrc | input | 3 | Source CPU of a pending software interrupt |
| acc | input | 1 | Register access this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accNs | input | 1 | Access is non-secure |
| accAddr | input | ADDR_W | Byte offset of the access |
| accWdata | input | 13 | Write data |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| rdData | output | 32 | Read data |
| irqOut | output | 1 | Interrupt request to the CPU |
| fiqOut | output | 1 | Fast interrupt request to the CPU |
| ackStb | output | 1 | One-cycle acknowledge pulse to the distributor |
| eoiStb | output | 1 | One-cycle completion pulse to the distributor |
| fbId | output | 10 | Identifier carried by the acknowledge or completion pulse |
| fbSrc | output | 3 | Source CPU carried by the acknowledge or completion pulse |

## Verification
The bench builds the block with a stack depth of 2 and the default identification value. With only two nested acknowledges the stack is full, so the refusal of a third acknowledge and the unwinding order of completions are both reached quickly. The distributor is driven directly from the bench. This lets each cross-security case be set up against either value of the cross-acknowledge bit, and lets the shared binary point be checked at its saturation value.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W   = 10;
  localparam int SRC_W  = 3;
  localparam int PRIO_W = 8;
  localparam int WD_W   = 13;

  localparam int OFF_CTL   = 'h100;
  localparam int OFF_PMR   = 'h104;
  localparam int OFF_BP    = 'h108;
  localparam int OFF_ACK   = 'h10C;
  localparam int OFF_EOI   = 'h110;
  localparam int OFF_RUN   = 'h114;
  localparam int OFF_HPP   = 'h118;
  localparam int OFF_ALIAS = 'h11C;
  localparam int OFF_IDENT = 'h120;

  localparam int CTL_EN_S   = 0;
  localparam int CTL_EN_NS  = 1;
  localparam int CTL_XACK   = 2;
  localparam int CTL_FIQ_RT = 3;
  localparam int CTL_SBPR   = 4;

  localparam logic [ID_W-1:0] ID_OTHER_WORLD = 10'd1022;
  localparam logic [ID_W-1:0] ID_NONE        = 10'd1023;
  localparam logic [PRIO_W-1:0] PRIO_IDLE    = 8'hF0;

  typedef enum logic [3:0] {
    RS_NONE, RS_CTL, RS_PMR, RS_BP, RS_ACK, RS_RUN, RS_HPP, RS_ALIAS, RS_IDENT
  } rsel_e;

  typedef struct packed {
    logic  rdEn;
    logic  accNs;
    logic  wrCtlFull;
    logic  wrCtlNs;
    logic  wrPmr;
    logic  wrBpS;
    logic  wrBpN;
    logic  ackTry;
    logic  eoiTry;
    rsel_e rsel;
  } strobe_t;

  typedef struct packed {
    logic [3:0]       prioHi;
    logic [ID_W-1:0]  id;
    logic [SRC_W-1:0] src;
    logic             ns;
  } entry_t;
endpackage

// File: rtl/cpuif_ctrl.sv
module cpuif_ctrl
  import cpuif_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acc,
  input  logic              accWrite,
  input  logic              accNs,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              sbpr,
  output strobe_t           stb
);
  always_comb begin
    stb       = '0;
    stb.rsel  = RS_NONE;
    stb.accNs = accNs;
    if (acc) begin
      stb.rdEn = !accWrite;
      case (accAddr)
        ADDR_W'(OFF_CTL): begin
          if (!accWrite) stb.rsel = RS_CTL;
          else if (accNs) stb.wrCtlNs = 1'b1;
          else stb.wrCtlFull = 1'b1;
        end
        ADDR_W'(OFF_PMR): begin
          if (!accWrite) stb.rsel = RS_PMR;
          else stb.wrPmr = 1'b1;
        end
        ADDR_W'(OFF_BP): begin
          if (!accWrite) stb.rsel = RS_BP;
          else if (!accNs) stb.wrBpS = 1'b1;
          else if (!sbpr) stb.wrBpN = 1'b1;
        end
        ADDR_W'(OFF_ACK): begin
          if (!accWrite) begin
            stb.rsel   = RS_ACK;
            stb.ackTry = 1'b1;
          end
        end
        ADDR_W'(OFF_EOI):   stb.eoiTry = accWrite;
        ADDR_W'(OFF_RUN):   if (!accWrite) stb.rsel = RS_RUN;
        ADDR_W'(OFF_HPP):   if (!accWrite) stb.rsel = RS_HPP;
        ADDR_W'(OFF_ALIAS): begin
          if (!accWrite) stb.rsel = RS_ALIAS;
          else if (!accNs) stb.wrBpN = 1'b1;
        end
        ADDR_W'(OFF_IDENT): if (!accWrite) stb.rsel = RS_IDENT;
        default: ;
      endcase
    end
  end

  // R11: a non-secure binary point write under the shared mode reaches no register
  p_ns_bp_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (acc && accWrite && accNs && sbpr && accAddr == ADDR_W'(OFF_BP)) |-> !(stb.wrBpS || stb.wrBpN));

  // R12: non-secure accesses never write through the alias
  p_alias_secure_only_r12: assert property (@(posedge clk) disable iff (!rstN)
    (acc && accWrite && accNs && accAddr == ADDR_W'(OFF_ALIAS)) |-> !stb.wrBpN);
endmodule

// File: rtl/cpuif_dpath.sv
module cpuif_dpath
  import cpuif_pkg::*;
#(
  parameter int          STACK_DEPTH = 4,
  parameter logic [31:0] IDENT_VALUE = 32'h3901_043B
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WD_W-1:0]   wdata,
  input  logic              pendValid,
  input  logic [ID_W-1:0]   pendId,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic              pendNs,
  input  logic [SRC_W-1:0]  pendSrc,
  output logic              sbpr,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              ackStb,
  output logic              eoiStb,
  output logic [ID_W-1:0]   fbId,
  output logic [SRC_W-1:0]  fbSrc
);
  localparam int SP_W  = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [4:0]        ctlReg;
  logic [4:0]        pmrReg;
  logic [2:0]        bpS, bpN, nsBpView;
  logic [SP_W-1:0]   count;
  logic [IDX_W-1:0]  topIdx;
  entry_t            entArr [STACK_DEPTH];
  entry_t            topEnt;
  logic [PRIO_W-1:0] runPrio, pmrFull;
  logic              eligible, full, push, pop;
  logic [ID_W-1:0]   viewId;
  logic              viewReal;
  logic [31:0]       ackWord, hppWord, rdMux;

  assign sbpr    = ctlReg[CTL_SBPR];
  assign full    = (count == SP_W'(STACK_DEPTH));
  assign topIdx  = IDX_W'(count - SP_W'(1));
  assign topEnt  = entArr[topIdx];
  assign runPrio = (count == '0) ? PRIO_IDLE : {topEnt.prioHi, 4'h0};
  assign pmrFull = {pmrReg, 3'b000};

  // Signalling gate: strictly more urgent than both mask and running level
  assign eligible = pendValid && (pendPrio < pmrFull) && (pendPrio < runPrio);
  assign irqOut = eligible && (pendNs ? ctlReg[CTL_EN_NS]
                                      : (ctlReg[CTL_EN_S] && !ctlReg[CTL_FIQ_RT]));
  assign fiqOut = eligible && !pendNs && ctlReg[CTL_EN_S] && ctlReg[CTL_FIQ_RT];

  // Identifier as seen by the current access's security state
  always_comb begin
    viewReal = 1'b0;
    viewId   = ID_NONE;
    if (pendValid) begin
      if (stb.accNs) begin
        if (pendNs) begin
          viewId   = pendId;
          viewReal = 1'b1;
        end
      end else if (pendNs && !ctlReg[CTL_XACK]) begin
        viewId = ID_OTHER_WORLD;
      end else begin
        viewId   = pendId;
        viewReal = 1'b1;
      end
    end
  end

  assign push = stb.ackTry && eligible && viewReal && !full;

  always_comb begin
    if (push)                ackWord = 32'({pendSrc, pendId});
    else if (eligible && !full) ackWord = 32'(viewId);
    else                     ackWord = 32'(ID_NONE);
    hppWord = viewReal ? 32'({pendSrc, viewId}) : 32'(viewId);
  end

  assign pop = stb.eoiTry && (count != '0)
            && (wdata[ID_W-1:0] == topEnt.id)
            && (wdata[WD_W-1:ID_W] == topEnt.src)
            && (stb.accNs ? topEnt.ns : (!topEnt.ns || ctlReg[CTL_XACK]));

  assign nsBpView = (bpS == 3'd7) ? 3'd7 : bpS + 3'd1;

  always_comb begin
    case (stb.rsel)
      RS_CTL:   rdMux = stb.accNs ? 32'(ctlReg & 5'b00010) : 32'(ctlReg);
      RS_PMR:   rdMux = 32'(pmrFull);
      RS_BP:    rdMux = stb.accNs ? 32'(ctlReg[CTL_SBPR] ? nsBpView : bpN) : 32'(bpS);
      RS_ACK:   rdMux = ackWord;
      RS_RUN:   rdMux = 32'(runPrio);
      RS_HPP:   rdMux = hppWord;
      RS_ALIAS: rdMux = stb.accNs ? 32'd0 : 32'(bpN);
      RS_IDENT: rdMux = IDENT_VALUE;
      default:  rdMux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg  <= '0;
      pmrReg  <= '0;
      bpS     <= '0;
      bpN     <= '0;
      count   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      ackStb  <= 1'b0;
      eoiStb  <= 1'b0;
      fbId    <= '0;
      fbSrc   <= '0;
    end else begin
      if (stb.wrCtlFull)    ctlReg <= wdata[4:0];
      else if (stb.wrCtlNs) ctlReg[CTL_EN_NS] <= wdata[CTL_EN_NS];
      if (stb.wrPmr) pmrReg <= wdata[7:3];
      if (stb.wrBpS) bpS <= wdata[2:0];
      if (stb.wrBpN) bpN <= wdata[2:0];
      if (push)     count <= count + SP_W'(1);
      else if (pop) count <= count - SP_W'(1);
      ackStb  <= push;
      eoiStb  <= pop;
      if (push) begin
        fbId  <= pendId;
        fbSrc <= pendSrc;
      end else if (pop) begin
        fbId  <= topEnt.id;
        fbSrc <= topEnt.src;
      end
      rdValid <= stb.rdEn;
      rdData  <= rdMux;
    end
  end

  for (genvar g = 0; g < STACK_DEPTH; g++) begin : gEntry
    entry_t entReg;
    always_ff @(posedge clk) begin
      if (push && count == SP_W'(g))
        entReg <= '{prioHi: pendPrio[7:4], id: pendId, src: pendSrc, ns: pendNs};
    end
    assign entArr[g] = entReg;
  end

  // R5: every acknowledge pulse follows one push of the active stack
  p_ack_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |-> count == $past(count) + SP_W'(1));
  // R8: every completion pulse follows one pop
  p_eoi_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    eoiStb |-> count == $past(count) - SP_W'(1));
  // R10: the stack never overflows
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    count <= SP_W'(STACK_DEPTH));
  // R4: the two request lines are exclusive
  p_one_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqOut, fiqOut}));
  // R4: a request is only raised for an interrupt under the mask
  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || fiqOut) |-> (pendValid && pendPrio < {pmrReg, 3'b000}));
  // R7: a read that returns a special code never acknowledges
  p_special_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && ackStb) |-> rdData[ID_W-1:0] < 32'd1020);
endmodule

// File: rtl/sec_cpu_intf.sv
module sec_cpu_intf
  import cpuif_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          STACK_DEPTH = 4,
  parameter logic [31:0] IDENT_VALUE = 32'h3901_043B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pendValid,
  input  logic [9:0]        pendId,
  input  logic [7:0]        pendPrio,
  input  logic              pendNs,
  input  logic [2:0]        pendSrc,
  input  logic              acc,
  input  logic              accWrite,
  input  logic              accNs,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [12:0]       accWdata,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              ackStb,
  output logic              eoiStb,
  output logic [9:0]        fbId,
  output logic [2:0]        fbSrc
);
  strobe_t stb;
  logic    sbpr;

  cpuif_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .acc(acc), .accWrite(accWrite), .accNs(accNs),
    .accAddr(accAddr), .sbpr(sbpr), .stb(stb)
  );

  cpuif_dpath #(.STACK_DEPTH(STACK_DEPTH), .IDENT_VALUE(IDENT_VALUE)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(accWdata),
    .pendValid(pendValid), .pendId(pendId), .pendPrio(pendPrio),
    .pendNs(pendNs), .pendSrc(pendSrc), .sbpr(sbpr),
    .rdValid(rdValid), .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut),
    .ackStb(ackStb), .eoiStb(eoiStb), .fbId(fbId), .fbSrc(fbSrc)
  );
endmodule

// File: tb/sim_sec_cpu_intf.sv
module sim_sec_cpu_intf;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pendValid = 1'b0, pendNs = 1'b0;
  logic [9:0] pendId = '0;
  logic [7:0] pendPrio = '0;
  logic [2:0] pendSrc = '0;
  logic acc = 1'b0, accWrite = 1'b0, accNs = 1'b0;
  logic [11:0] accAddr = '0;
  logic [12:0] accWdata = '0;
  logic rdValid, irqOut, fiqOut, ackStb, eoiStb;
  logic [31:0] rdData;
  logic [9:0] fbId;
  logic [2:0] fbSrc;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  localparam logic [11:0] A_CTL = 12'h100, A_PMR = 12'h104, A_BP = 12'h108,
    A_ACK = 12'h10C, A_EOI = 12'h110, A_RUN = 12'h114, A_HPP = 12'h118,
    A_ALIAS = 12'h11C, A_IDENT = 12'h120;

  always #10 clk = ~clk;

  sec_cpu_intf #(.STACK_DEPTH(2)) u0 (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .pendId(pendId),
    .pendPrio(pendPrio), .pendNs(pendNs), .pendSrc(pendSrc), .acc(acc),
    .accWrite(accWrite), .accNs(accNs), .accAddr(accAddr), .accWdata(accWdata),
    .rdValid(rdValid), .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut),
    .ackStb(ackStb), .eoiStb(eoiStb), .fbId(fbId), .fbSrc(fbSrc)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each returned read against the scoreboard head
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL scoreboard unexpected read actual=%0h expected=none", rdData);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(rdData, e, t);
      end
    end
  end

  task automatic access(input logic [11:0] a, input logic w, input logic ns, input logic [12:0] d);
    @(negedge clk);
    acc = 1'b1; accWrite = w; accNs = ns; accAddr = a; accWdata = d;
    @(negedge clk);
    acc = 1'b0; accWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic ns, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    access(a, 1'b0, ns, '0);
  endtask

  task automatic wr(input logic [11:0] a, input logic ns, input logic [12:0] d);
    access(a, 1'b1, ns, d);
  endtask

  task automatic setPend(input logic v, input logic [9:0] id, input logic [7:0] p,
                         input logic ns, input logic [2:0] src);
    @(negedge clk);
    pendValid = v; pendId = id; pendPrio = p; pendNs = ns; pendSrc = src;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk({30'd0, irqOut, fiqOut}, 32'd0, "R1 lines low after reset");
    rd(A_CTL, 1'b0, 32'h0, "R1 control reset");
    rd(A_PMR, 1'b0, 32'h0, "R1 mask reset");
    rd(A_BP, 1'b0, 32'h0, "R1 secure bp reset");
    rd(A_ALIAS, 1'b0, 32'h0, "R1 ns bp reset");
    rd(A_RUN, 1'b0, 32'hF0, "R1 running idle");
    rd(A_ACK, 1'b0, 32'd1023, "R1 ack empty");
    // R3 identification
    rd(A_IDENT, 1'b0, 32'h3901043B, "R3 ident value");
    wr(A_IDENT, 1'b0, 13'h0);
    rd(A_IDENT, 1'b1, 32'h3901043B, "R3 ident after write");
    // R2 / R12 control layout and banked view
    wr(A_CTL, 1'b0, 13'h1F);
    rd(A_CTL, 1'b0, 32'h1F, "R2 control all bits");
    rd(A_CTL, 1'b1, 32'h02, "R12 ns control view");
    wr(A_CTL, 1'b1, 13'h0);
    rd(A_CTL, 1'b0, 32'h1D, "R12 ns write touches bit1 only");
    wr(A_CTL, 1'b0, 13'h03);
    wr(A_PMR, 1'b0, 13'hFF);
    rd(A_PMR, 1'b0, 32'hF8, "R2 mask bits 7:3");
    wr(A_PMR, 1'b0, 13'h48);
    // R4 signalling
    setPend(1'b1, 10'd40, 8'h40, 1'b0, 3'd0);
    chk({30'd0, irqOut, fiqOut}, 32'h2, "R4 secure to irq");
    wr(A_CTL, 1'b0, 13'h0B);
    chk({30'd0, irqOut, fiqOut}, 32'h1, "R4 secure to fiq");
    wr(A_PMR, 1'b0, 13'h40);
    chk({30'd0, irqOut, fiqOut}, 32'h0, "R4 equal mask blocks");
    wr(A_PMR, 1'b0, 13'h48);
    wr(A_CTL, 1'b0, 13'h0A);
    chk({30'd0, irqOut, fiqOut}, 32'h0, "R4 secure enable off");
    wr(A_CTL, 1'b0, 13'h0B);
    chk({30'd0, irqOut, fiqOut}, 32'h1, "R4 fiq restored");
    // R13 / R7
    rd(A_HPP, 1'b0, 32'd40, "R13 secure hpp");
    rd(A_HPP, 1'b1, 32'd1023, "R13 ns hpp of secure");
    rd(A_ACK, 1'b1, 32'd1023, "R7 ns ack of secure");
    chk(32'(ackStb), 32'd0, "R7 no pulse on 1023");
    rd(A_RUN, 1'b0, 32'hF0, "R7 running unchanged");
    // R5 acknowledge
    rd(A_ACK, 1'b0, 32'd40, "R5 secure ack");
    chk({19'd0, ackStb, fbSrc, fbId}, {19'd1, 3'd0, 10'd40}, "R5 ack pulse");
    @(negedge clk);
    chk(32'(ackStb), 32'd0, "R5 pulse one cycle");
    rd(A_RUN, 1'b0, 32'h40, "R10 running after ack");
    chk({30'd0, irqOut, fiqOut}, 32'h0, "R4 running level blocks");
    // R6 nested non-secure
    setPend(1'b1, 10'd5, 8'h20, 1'b1, 3'd3);
    chk({30'd0, irqOut, fiqOut}, 32'h2, "R4 ns to irq");
    rd(A_ACK, 1'b0, 32'd1022, "R6 secure ack xack0");
    chk(32'(ackStb), 32'd0, "R6 no pulse on 1022");
    rd(A_HPP, 1'b0, 32'd1022, "R13 secure hpp of ns");
    rd(A_RUN, 1'b0, 32'h40, "R6 running unchanged");
    rd(A_ACK, 1'b1, 32'hC05, "R5 ns ack with source");
    chk({19'd0, ackStb, fbSrc, fbId}, {19'd1, 3'd3, 10'd5}, "R5 ns ack pulse");
    rd(A_RUN, 1'b0, 32'h20, "R10 nested running");
    // R10 full stack
    setPend(1'b1, 10'd33, 8'h10, 1'b0, 3'd0);
    rd(A_ACK, 1'b0, 32'd1023, "R10 full stack refuses");
    chk(32'(ackStb), 32'd0, "R10 no pulse when full");
    setPend(1'b0, 10'd0, 8'h0, 1'b0, 3'd0);
    // R8 / R9 completion
    wr(A_EOI, 1'b0, {3'd3, 10'd5});
    chk(32'(eoiStb), 32'd0, "R9 secure eoi of ns ignored");
    rd(A_RUN, 1'b0, 32'h20, "R9 running kept");
    wr(A_EOI, 1'b1, {3'd3, 10'd6});
    chk(32'(eoiStb), 32'd0, "R8 mismatched eoi ignored");
    wr(A_EOI, 1'b1, {3'd3, 10'd5});
    chk({19'd0, eoiStb, fbSrc, fbId}, {19'd1, 3'd3, 10'd5}, "R8 eoi pulse");
    rd(A_RUN, 1'b0, 32'h40, "R8 pop to outer");
    wr(A_EOI, 1'b1, {3'd0, 10'd40});
    chk(32'(eoiStb), 32'd0, "R9 ns eoi of secure ignored");
    rd(A_RUN, 1'b0, 32'h40, "R9 secure active kept");
    wr(A_EOI, 1'b0, {3'd0, 10'd40});
    chk(32'(eoiStb), 32'd1, "R8 secure eoi pulse");
    rd(A_RUN, 1'b0, 32'hF0, "R8 back to idle");
    // R6 / R9 with cross acknowledge on
    wr(A_CTL, 1'b0, 13'h07);
    setPend(1'b1, 10'd50, 8'h30, 1'b1, 3'd0);
    rd(A_ACK, 1'b0, 32'd50, "R6 secure ack xack1");
    chk(32'(ackStb), 32'd1, "R6 xack1 pulse");
    setPend(1'b0, 10'd0, 8'h0, 1'b0, 3'd0);
    wr(A_EOI, 1'b0, {3'd0, 10'd50});
    chk(32'(eoiStb), 32'd1, "R9 secure eoi xack1");
    rd(A_RUN, 1'b0, 32'hF0, "R9 deactivated");
    // R11 / R12 binary points
    wr(A_BP, 1'b0, 13'h5);
    rd(A_BP, 1'b0, 32'h5, "R11 secure bp");
    wr(A_BP, 1'b1, 13'h2);
    rd(A_BP, 1'b1, 32'h2, "R12 ns bp separate");
    rd(A_ALIAS, 1'b0, 32'h2, "R12 alias view");
    wr(A_CTL, 1'b0, 13'h13);
    rd(A_BP, 1'b1, 32'h6, "R11 ns read plus one");
    wr(A_BP, 1'b1, 13'h1);
    rd(A_ALIAS, 1'b0, 32'h2, "R11 ns write ignored");
    rd(A_BP, 1'b0, 32'h5, "R11 secure bp kept");
    wr(A_BP, 1'b0, 13'h6);
    rd(A_BP, 1'b1, 32'h7, "R11 six plus one");
    wr(A_BP, 1'b0, 13'h7);
    rd(A_BP, 1'b1, 32'h7, "R11 saturate at 7");
    rd(A_ALIAS, 1'b1, 32'h0, "R12 ns alias reads zero");
    wr(A_ALIAS, 1'b1, 13'h3);
    rd(A_ALIAS, 1'b0, 32'h2, "R12 ns alias write ignored");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFail++;
      $display("FAIL scoreboard undrained actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule